// File: doc/BRIEF.md
# Low-Rate Real-Time Counter with Match Alarms

This peripheral keeps a 32-bit running count of time at a low, programmable rate. The caller supplies a one-cycle enable, `ref_en`, for each edge of a 32768 Hz reference. A half-period prescaler turns those enables into a tick every 2×(DIV+1) reference edges, and each tick advances the counter by one. With a divider of 1023 the counter runs at 16 Hz. Everything runs in the single `clk` domain.

Software reaches the block through a plain 32-bit register port that uses byte offsets. Writes take effect on the clock edge where `bus_en` and `bus_we` are both high. Reads are combinational from `bus_addr`. The port has no back-pressure and never stalls, so it has no valid/ready handshake. The register map is:

| Offset | Register |
|--------|----------|
| 0x00 | counter |
| 0x04 | match A |
| 0x08 | status |
| 0x0C | divider |
| 0x14 | deep-control word |
| 0x18 | match B |
| 0x1C | source select |
| 0x40 | keep word |

Two match registers compare against the counter. The status register holds three event flags and their enables. The keep word lets software record how many times the counter has wrapped. `irq` is a registered OR of every flag that has its enable set.

Top module: `lowrate_rtc`

## Requirements
- R1: After reset every register reads 0. This covers the counter, both match values, status, divider, source select, deep-control and keep. `irq` is 0.
- R2: While source select holds 3, the counter goes up by one on every 2×(DIV+1)-th `ref_en` pulse. It does not change on any other cycle unless software writes it.
- R3: While source select is any value other than 3, the prescaler stays cleared and the counter does not tick. Source select reads back its 2-bit value.
- R4: Software can write the counter directly. On a tick it wraps from 0xFFFFFFFF to 0.
- R5: A match flag sets when the counter takes on that match register's value. The flag is status bit 0 for match A and bit 4 for match B. Both a tick and a software counter write can cause the match, and the flag sets whether or not its enable is on.
- R6: The flag bits 0, 1 and 4 are cleared by writing 1. Writing 0 leaves them unchanged. If a flag sets and is cleared in the same cycle, the set wins.
- R7: Status bits 2, 3 and 6 are plain read/write enables, for match A, tick and match B respectively. All other status bits read 0.
- R8: Status bit 1 sets on every tick.
- R9: `irq` equals (bit0&bit2)|(bit1&bit3)|(bit4&bit6) as it stood one cycle earlier. It therefore drops on the cycle after the flags clear.
- R10: The keep word (0x40) and the deep-control word (0x14) are 32-bit read/write registers. Counting never changes them.
- R11: Reads from an undefined offset return 0, and writes to one change nothing.
- R12: A write to the divider restarts the prescaler, so the next tick comes a full 2×(DIV+1) pulses later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One pulse per reference-clock edge |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: 32-bit data, an 8-bit offset, a 16-bit divider and a 2-bit source select. Because `ref_en` is under bench control, it programs small divider values (0 and 3), so each tick costs only a few pulses. Those values make the exact tick boundary and a prescaler restart part-way through a period quick to observe. Writing the counter close to 0xFFFFFFFF brings the wrap into reach within a few pulses. With both match values left at 0, the wrap also exercises the match path.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_MATCH = 2;

  localparam logic [7:0] OFF_COUNT = 8'h00;
  localparam logic [7:0] OFF_MATCH_A = 8'h04;
  localparam logic [7:0] OFF_STATUS = 8'h08;
  localparam logic [7:0] OFF_DIV = 8'h0C;
  localparam logic [7:0] OFF_DEEP = 8'h14;
  localparam logic [7:0] OFF_MATCH_B = 8'h18;
  localparam logic [7:0] OFF_SRC = 8'h1C;
  localparam logic [7:0] OFF_KEEP = 8'h40;

  localparam int TICK_FLAG_BIT = 1;
  localparam int TICK_EN_BIT = 3;

  localparam logic [1:0] SRC_REF = 2'd3;

  function automatic logic [7:0] match_off(input int idx);
    return (idx == 0) ? OFF_MATCH_A : OFF_MATCH_B;
  endfunction

  function automatic int match_flag_bit(input int idx);
    return (idx == 0) ? 0 : 4;
  endfunction

  function automatic int match_en_bit(input int idx);
    return (idx == 0) ? 2 : 6;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ref_en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] half_q;
  logic             phase_q;
  logic             at_end;

  assign at_end = (half_q == div);
  assign tick   = run & ~restart & ref_en & at_end & phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= '0;
      phase_q <= 1'b0;
    end else if (restart || !run) begin
      half_q  <= '0;
      phase_q <= 1'b0;
    end else if (ref_en) begin
      if (at_end) begin
        half_q  <= '0;
        phase_q <= ~phase_q;
      end else begin
        half_q <= half_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] next,
  output logic             update
);
  logic [CNT_W-1:0] cnt_q;

  assign next   = load ? load_val : cnt_q + 1'b1;
  assign update = load | tick;
  assign count  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (update) cnt_q <= next;
  end
endmodule

// File: rtl/rtc_match.sv
module rtc_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             update,
  input  logic [CNT_W-1:0] next,
  output logic [CNT_W-1:0] value,
  output logic             hit
);
  logic [CNT_W-1:0] value_q;

  assign value = value_q;
  assign hit   = update & (next == value_q);

  always_ff @(posedge clk) begin
    if (!rst_n) value_q <= '0;
    else if (wr) value_q <= wdata;
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_MATCH-1:0] match_set,
  input  logic              tick_set,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [NUM_MATCH-1:0] mflag_q, men_q;
  logic                 tflag_q, ten_q;
  logic                 pending;
  logic                 irq_q;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    localparam int FB = match_flag_bit(i);
    localparam int EB = match_en_bit(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mflag_q[i] <= 1'b0;
        men_q[i]   <= 1'b0;
      end else begin
        mflag_q[i] <= (mflag_q[i] & ~(wr & wdata[FB])) | match_set[i];
        if (wr) men_q[i] <= wdata[EB];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tflag_q <= 1'b0;
      ten_q   <= 1'b0;
    end else begin
      tflag_q <= (tflag_q & ~(wr & wdata[TICK_FLAG_BIT])) | tick_set;
      if (wr) ten_q <= wdata[TICK_EN_BIT];
    end
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_MATCH; i++) begin
      status[match_flag_bit(i)] = mflag_q[i];
      status[match_en_bit(i)]   = men_q[i];
    end
    status[TICK_FLAG_BIT] = tflag_q;
    status[TICK_EN_BIT]   = ten_q;
  end

  assign pending = |(mflag_q & men_q) | (tflag_q & ten_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= pending;
  end

  assign irq = irq_q;
endmodule

// File: rtl/lowrate_rtc.sv
module lowrate_rtc
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [SRC_W-1:0] SRC_ON = SRC_W'(SRC_REF);

  logic wr;
  logic cnt_wr, status_wr, div_wr, deep_wr, src_wr, keep_wr;
  logic [NUM_MATCH-1:0] match_wr;

  assign wr        = bus_en & bus_we;
  assign cnt_wr    = wr & (bus_addr == ADDR_W'(OFF_COUNT));
  assign status_wr = wr & (bus_addr == ADDR_W'(OFF_STATUS));
  assign div_wr    = wr & (bus_addr == ADDR_W'(OFF_DIV));
  assign deep_wr   = wr & (bus_addr == ADDR_W'(OFF_DEEP));
  assign src_wr    = wr & (bus_addr == ADDR_W'(OFF_SRC));
  assign keep_wr   = wr & (bus_addr == ADDR_W'(OFF_KEEP));

  logic [DIV_W-1:0]  div_q;
  logic [SRC_W-1:0]  src_sel;
  logic [DATA_W-1:0] deep_q, keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      src_sel <= '0;
      deep_q  <= '0;
      keep_q  <= '0;
    end else begin
      if (div_wr)  div_q   <= bus_wdata[DIV_W-1:0];
      if (src_wr)  src_sel <= bus_wdata[SRC_W-1:0];
      if (deep_wr) deep_q  <= bus_wdata;
      if (keep_wr) keep_q  <= bus_wdata;
    end
  end

  logic tick;
  rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(src_sel == SRC_ON), .restart(div_wr),
    .ref_en(ref_en), .div(div_q), .tick(tick)
  );

  logic [DATA_W-1:0] count, cnt_next;
  logic              cnt_update;
  rtc_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr), .load_val(bus_wdata),
    .count(count), .next(cnt_next), .update(cnt_update)
  );

  logic [DATA_W-1:0]    match_val [NUM_MATCH];
  logic [NUM_MATCH-1:0] match_hit;
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign match_wr[i] = wr & (bus_addr == ADDR_W'(match_off(i)));
    rtc_match #(.CNT_W(DATA_W)) u_match (
      .clk(clk), .rst_n(rst_n), .wr(match_wr[i]), .wdata(bus_wdata),
      .update(cnt_update), .next(cnt_next), .value(match_val[i]), .hit(match_hit[i])
    );
  end

  logic [DATA_W-1:0] status;
  rtc_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr(status_wr), .wdata(bus_wdata),
    .match_set(match_hit), .tick_set(tick), .status(status), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_COUNT))  bus_rdata = count;
    if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = status;
    if (bus_addr == ADDR_W'(OFF_DIV))    bus_rdata = DATA_W'(div_q);
    if (bus_addr == ADDR_W'(OFF_DEEP))   bus_rdata = deep_q;
    if (bus_addr == ADDR_W'(OFF_SRC))    bus_rdata = DATA_W'(src_sel);
    if (bus_addr == ADDR_W'(OFF_KEEP))   bus_rdata = keep_q;
    for (int i = 0; i < NUM_MATCH; i++)
      if (bus_addr == ADDR_W'(match_off(i))) bus_rdata = match_val[i];
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int DATA_W = 32,
  parameter int SRC_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cnt_wr,
  input logic [DATA_W-1:0] count,
  input logic [SRC_W-1:0]  src_sel,
  input logic [1:0]        match_hit,
  input logic [DATA_W-1:0] status,
  input logic              irq
);
  logic pend;
  assign pend = (status[0] & status[2]) | (status[1] & status[3]) | (status[4] & status[6]);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count == $past(count) + 1'b1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));

  p_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != SRC_W'(3)) |-> !tick);

  p_flag_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit[0] |=> status[0]);

  p_flag_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit[1] |=> status[4]);

  p_tick_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> status[1]);

  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past(pend)));

  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> ((status & ~DATA_W'(32'h5F)) == '0));
endmodule

bind lowrate_rtc rtc_checker #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .count(count),
  .src_sel(src_sel), .match_hit(match_hit), .status(status), .irq(irq)
);

// File: tb/sim_lowrate_rtc.sv
`timescale 1ns/1ps
module sim_lowrate_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int failed = 0;

  always #2.5 clk = ~clk;

  lowrate_rtc u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_en = 1'b1;
    end
    @(negedge clk);
    ref_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 counter", v, 0);
    rd(8'h04, v); check("R1 match A", v, 0);
    rd(8'h18, v); check("R1 match B", v, 0);
    rd(8'h08, v); check("R1 status", v, 0);
    rd(8'h0C, v); check("R1 divider", v, 0);
    rd(8'h1C, v); check("R1 source select", v, 0);
    rd(8'h40, v); check("R1 keep", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_undefined();
    logic [31:0] v;
    wr(8'h10, 32'hDEADBEEF);
    wr(8'h20, 32'h12345678);
    rd(8'h10, v); check("R11 read 0x10", v, 0);
    rd(8'h20, v); check("R11 read 0x20", v, 0);
    rd(8'h00, v); check("R11 counter untouched", v, 0);
  endtask

  task automatic t_stopped();
    logic [31:0] v;
    wr(8'h1C, 32'h2);
    rd(8'h1C, v); check("R3 source readback", v, 2);
    wr(8'h0C, 32'h0);
    pulses(10);
    rd(8'h00, v); check("R3 no count while stopped", v, 0);
    rd(8'h08, v); check("R3 no tick flag while stopped", v, 0);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    wr(8'h40, 32'hA5A5_0001);
    wr(8'h14, 32'h0000_BEEF);
    wr(8'h1C, 32'h3);
    wr(8'h0C, 32'h3);
    wr(8'h00, 32'd100);
    pulses(7);
    rd(8'h00, v); check("R2 no tick before 8 pulses", v, 100);
    pulses(1);
    rd(8'h00, v); check("R2 tick on 8th pulse", v, 101);
    rd(8'h08, v); check("R8 tick flag", v & 32'h2, 32'h2);
    pulses(8);
    rd(8'h00, v); check("R2 second tick", v, 102);
    pulses(5);
    wr(8'h0C, 32'h3);
    pulses(7);
    rd(8'h00, v); check("R12 restart delays tick", v, 102);
    pulses(1);
    rd(8'h00, v); check("R12 tick after full period", v, 103);
    rd(8'h40, v); check("R10 keep held", v, 32'hA5A5_0001);
    rd(8'h14, v); check("R10 deep-control held", v, 32'h0000_BEEF);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h13);
    wr(8'h00, 32'hFFFF_FFFE);
    pulses(2);
    rd(8'h00, v); check("R4 reaches max", v, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R5 no match flags yet", v & 32'h11, 0);
    pulses(2);
    rd(8'h00, v); check("R4 wrap to zero", v, 0);
    rd(8'h08, v); check("R5 zero match sets both flags", v & 32'h11, 32'h11);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr(8'h04, 32'd50);
    wr(8'h18, 32'd60);
    wr(8'h08, 32'h17);
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'd48);
    pulses(2);
    rd(8'h08, v); check("R5 no flag at 49", v & 32'h1, 0);
    check("R9 irq low", {31'b0, irq}, 0);
    pulses(2);
    check("R9 irq still low in flag cycle", {31'b0, irq}, 0);
    @(negedge clk);
    check("R9 irq high after flag", {31'b0, irq}, 1);
    rd(8'h08, v); check("R5 flag A and tick flag", v, 32'h07);
    wr(8'h00, 32'd60);
    rd(8'h08, v); check("R5 write match sets B flag", v, 32'h17);
    wr(8'h08, 32'h05);
    check("R9 irq lags clear", {31'b0, irq}, 1);
    @(negedge clk);
    check("R9 irq drops", {31'b0, irq}, 0);
    rd(8'h08, v); check("R6 only written-one bit cleared", v, 32'h16);
    wr(8'h08, 32'h44);
    @(negedge clk);
    check("R9 irq from match B", {31'b0, irq}, 1);
    rd(8'h08, v); check("R6 zero write keeps flags", v, 32'h56);
    wr(8'h08, 32'h58);
    @(negedge clk);
    check("R9 irq from tick", {31'b0, irq}, 1);
    wr(8'h08, 32'h4A);
    @(negedge clk);
    check("R9 irq clear all", {31'b0, irq}, 0);
    rd(8'h08, v); check("R7 enables read back", v, 32'h48);
    wr(8'h08, 32'hFFFF_FFA0);
    rd(8'h08, v); check("R7 reserved bits read 0", v, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    failed++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_undefined();
    t_stopped();
    t_tick();
    t_wrap();
    t_alarm();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule